// File: doc/BRIEF.md
# TDM Timeslot-to-Packet Context Assembler

The block turns a constant-bit-rate TDM byte stream into fixed-size payloads. Each byte arrives tagged with its stream and timeslot number. A host-programmed lookup table assigns each (stream, timeslot) pair to a packetisation context, or marks it unused. Every context gathers its bytes, in arrival order, into a two-bank assembly cache.

When a context has gathered its programmed payload length, the bank it filled is handed over for writing to packet memory. The context then carries on in the other bank, so the TDM side never stalls. Completed payloads are offered on a request/grant port as one wide word. When several payloads wait, the lowest context number goes first.

The host controls each context with three commands:
- open: set the length and start assembling;
- update: a new length that starts with the next payload;
- teardown: stop the context at the next payload boundary.

A payload that completes while the same context's previous payload is still waiting for a grant is dropped, and the context raises a sticky overflow flag.

Top module: `tdm_ctx_assembler`

## Requirements
- R1: After reset no request is raised, all overflow flags are 0 and every lookup entry is invalid, so every byte is discarded.
- R2: A byte on stream s, timeslot t uses lookup entry s*NSLOT+t. An entry written with valid=1 routes bytes to its context number. An entry with valid=0 discards the byte. A rewritten entry takes effect from the following byte.
- R3: A context's payload is its next len bytes in arrival order, with 1 <= len <= MAXLEN. While the payload is offered, byte i of the payload sits in mem_data bits [8i+7:8i], and mem_len equals the length that payload was built with.
- R4: cmd_op 0 (open) activates the context with length cmd_len, restarts its fill at zero and clears its overflow flag. An inactive context discards its bytes.
- R5: cmd_op 1 (update) sets a new length. If the context is mid-payload, the payload in progress keeps its old length and the new length starts with the next payload. At fill zero the new length applies at once.
- R6: cmd_op 2 (teardown) deactivates the context when its current payload completes, or at once if its fill is zero. Later bytes for it are discarded. cmd_op 3 has no effect.
- R7: On the clock edge that accepts a payload's last byte, the payload becomes pending, and mem_req is high from that edge. The context keeps accepting bytes into its other bank while the payload waits.
- R8: mem_req stays high while any payload is pending. mem_ctx names the lowest-numbered pending context. A cycle with mem_req and mem_gnt both high consumes that payload.
- R9: If a context completes a payload while its previous one is still pending and not granted in that same cycle, ctx_ovf[c] is set and stays set until the context is opened. The new payload is dropped and the pending one is kept.
- R10: When a host command and a byte for the same context arrive in the same cycle, the command is applied and the byte is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_valid | input | 1 | A TDM byte is present this cycle |
| tdm_stream | input | SW | Stream number of the byte |
| tdm_slot | input | TW | Timeslot number of the byte |
| tdm_data | input | DW | TDM byte |
| lut_we | input | 1 | Write one lookup entry |
| lut_idx | input | LIW | Entry index, stream*NSLOT+timeslot |
| lut_valid | input | 1 | Entry is in use |
| lut_ctx | input | CW | Context number for the entry |
| cmd_we | input | 1 | Apply a context command |
| cmd_op | input | 2 | 0 open, 1 update, 2 teardown, 3 none |
| cmd_ctx | input | CW | Context the command targets |
| cmd_len | input | LW | Payload length for open/update |
| mem_req | output | 1 | A completed payload is waiting |
| mem_gnt | input | 1 | Packet memory accepts the offered payload |
| mem_ctx | output | CW | Context of the offered payload |
| mem_len | output | LW | Byte length of the offered payload |
| mem_data | output | MAXLEN*DW | Offered payload, byte 0 in the low bits |
| ctx_ovf | output | NCTX | Sticky per-context overflow flags |

## Verification
The bench uses the default parameters: two streams of eight timeslots, four contexts and a maximum payload of eight bytes. With these values, a one-byte payload and a full eight-byte payload can be run side by side. All four contexts compete for the grant within a few cycles, and an overflow is reached by holding the grant low for a single extra payload. A randomised phase then mixes lookup rewrites, commands, byte traffic and grants, and the bench compares the design against its reference model on every clock.

// File: rtl/tdm_ctx_assembler.sv
module tdm_ctx_assembler #(
  parameter int NSTREAM = 2,
  parameter int NSLOT   = 8,
  parameter int NCTX    = 4,
  parameter int MAXLEN  = 8,
  parameter int DW      = 8,
  localparam int NLUT = NSTREAM * NSLOT,
  localparam int SW   = (NSTREAM > 1) ? $clog2(NSTREAM) : 1,
  localparam int TW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int LIW  = (NLUT > 1) ? $clog2(NLUT) : 1,
  localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int LW   = $clog2(MAXLEN + 1),
  localparam int FW   = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tdm_valid,
  input  logic [SW-1:0]        tdm_stream,
  input  logic [TW-1:0]        tdm_slot,
  input  logic [DW-1:0]        tdm_data,
  input  logic                 lut_we,
  input  logic [LIW-1:0]       lut_idx,
  input  logic                 lut_valid,
  input  logic [CW-1:0]        lut_ctx,
  input  logic                 cmd_we,
  input  logic [1:0]           cmd_op,
  input  logic [CW-1:0]        cmd_ctx,
  input  logic [LW-1:0]        cmd_len,
  output logic                 mem_req,
  input  logic                 mem_gnt,
  output logic [CW-1:0]        mem_ctx,
  output logic [LW-1:0]        mem_len,
  output logic [MAXLEN*DW-1:0] mem_data,
  output logic [NCTX-1:0]      ctx_ovf
);

  logic [NLUT-1:0] lv;
  logic [CW-1:0]   lc [NLUT];
  logic [DW-1:0]   cache [NCTX][2][MAXLEN];

  logic [NCTX-1:0] act, upd, td, full, bank, ovf;
  logic [LW-1:0]   len  [NCTX];
  logic [LW-1:0]   nlen [NCTX];
  logic [LW-1:0]   plen [NCTX];
  logic [LW-1:0]   fill [NCTX];

  logic [LIW-1:0] lidx;
  logic [CW-1:0]  hc, sel;
  logic           acc, grant;

  assign lidx  = LIW'(tdm_stream) * LIW'(NSLOT) + LIW'(tdm_slot);
  assign hc    = lc[lidx];
  assign acc   = tdm_valid && lv[lidx] && act[hc] && !(cmd_we && cmd_ctx == hc);
  assign grant = mem_req && mem_gnt;

  always_comb begin
    sel = '0;
    for (int c = NCTX - 1; c >= 0; c--)
      if (full[c]) sel = CW'(c);
  end

  assign mem_req = |full;
  assign mem_ctx = sel;
  assign mem_len = plen[sel];
  assign ctx_ovf = ovf;

  for (genvar i = 0; i < MAXLEN; i++) begin : g_out
    assign mem_data[i*DW +: DW] = cache[sel][!bank[sel]][i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lv <= '0;
    else if (lut_we) lv[lut_idx] <= lut_valid;

  always_ff @(posedge clk)
    if (lut_we) lc[lut_idx] <= lut_ctx;

  always_ff @(posedge clk)
    if (acc) cache[hc][bank[hc]][fill[hc][FW-1:0]] <= tdm_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {act, upd, td, full, bank, ovf} <= '0;
      for (int c = 0; c < NCTX; c++) begin
        len[c]  <= '0;
        nlen[c] <= '0;
        plen[c] <= '0;
        fill[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NCTX; c++) begin
        if (grant && sel == CW'(c)) full[c] <= 1'b0;
        if (cmd_we && cmd_ctx == CW'(c)) begin
          case (cmd_op)
            2'd0: begin
              act[c] <= 1'b1; len[c] <= cmd_len; fill[c] <= '0;
              upd[c] <= 1'b0; td[c] <= 1'b0; ovf[c] <= 1'b0;
            end
            2'd1:
              if (fill[c] == '0) begin len[c] <= cmd_len; upd[c] <= 1'b0; end
              else begin nlen[c] <= cmd_len; upd[c] <= 1'b1; end
            2'd2:
              if (fill[c] == '0) begin act[c] <= 1'b0; td[c] <= 1'b0; end
              else td[c] <= 1'b1;
            default: ;
          endcase
        end else if (acc && hc == CW'(c)) begin
          if (fill[c] + LW'(1) == len[c]) begin
            fill[c] <= '0;
            if (full[c] && !(grant && sel == CW'(c))) ovf[c] <= 1'b1;
            else begin
              full[c] <= 1'b1;
              bank[c] <= ~bank[c];
              plen[c] <= len[c];
            end
            if (upd[c]) begin len[c] <= nlen[c]; upd[c] <= 1'b0; end
            if (td[c])  begin act[c] <= 1'b0;    td[c]  <= 1'b0; end
          end else begin
            fill[c] <= fill[c] + LW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/tdm_ctx_assembler_chk.sv
module tdm_ctx_assembler_chk #(
  parameter int NCTX   = 4,
  parameter int MAXLEN = 8,
  parameter int LW     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_gnt,
  input logic [LW-1:0]   mem_len,
  input logic            cmd_we,
  input logic [1:0]      cmd_op,
  input logic [NCTX-1:0] ctx_ovf
);

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_we && cmd_op == 2'd0) |=> ((ctx_ovf & $past(ctx_ovf)) == $past(ctx_ovf)));

  a_r9_ovf_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctx_ovf & ~$past(ctx_ovf)) != '0) |-> $past(mem_req));

  a_r3_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0 && mem_len <= LW'(MAXLEN)));

endmodule

bind tdm_ctx_assembler tdm_ctx_assembler_chk #(.NCTX(NCTX), .MAXLEN(MAXLEN), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_len(mem_len),
  .cmd_we(cmd_we), .cmd_op(cmd_op), .ctx_ovf(ctx_ovf)
);

// File: tb/tdm_ctx_assembler_test.sv
module tdm_ctx_assembler_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tdm_valid = 1'b0, lut_we = 1'b0, lut_valid = 1'b0, cmd_we = 1'b0, mem_gnt = 1'b0;
  logic [0:0] tdm_stream = '0;
  logic [2:0] tdm_slot = '0;
  logic [7:0] tdm_data = '0;
  logic [3:0] lut_idx = '0;
  logic [1:0] lut_ctx = '0, cmd_op = 2'd3, cmd_ctx = '0;
  logic [3:0] cmd_len = '0;
  logic       mem_req;
  logic [1:0] mem_ctx;
  logic [3:0] mem_len;
  logic [63:0] mem_data;
  logic [3:0] ctx_ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  tdm_ctx_assembler uut (
    .clk(clk), .rst_n(rst_n), .tdm_valid(tdm_valid), .tdm_stream(tdm_stream),
    .tdm_slot(tdm_slot), .tdm_data(tdm_data), .lut_we(lut_we), .lut_idx(lut_idx),
    .lut_valid(lut_valid), .lut_ctx(lut_ctx), .cmd_we(cmd_we), .cmd_op(cmd_op),
    .cmd_ctx(cmd_ctx), .cmd_len(cmd_len), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_ctx(mem_ctx), .mem_len(mem_len), .mem_data(mem_data), .ctx_ovf(ctx_ovf)
  );

  // reference model
  int m_lv[16], m_lc[16];
  int m_act[4], m_len[4], m_nlen[4], m_upd[4], m_td[4], m_ovf[4], m_pend[4], m_plen[4], m_fill[4];
  int m_cur[4][8], m_pay[4][8];
  int g, x, idx;

  function automatic int exp_sel();
    for (int c = 0; c < 4; c++) if (m_pend[c] != 0) return c;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_lv[i] = 0; m_lc[i] = 0; end
      for (int c = 0; c < 4; c++) begin
        m_act[c] = 0; m_len[c] = 0; m_nlen[c] = 0; m_upd[c] = 0; m_td[c] = 0;
        m_ovf[c] = 0; m_pend[c] = 0; m_plen[c] = 0; m_fill[c] = 0;
      end
    end else begin
      g = exp_sel();
      if (mem_gnt && g >= 0) m_pend[g] = 0;
      if (cmd_we) begin
        x = int'(cmd_ctx);
        if (cmd_op == 2'd0) begin
          m_act[x] = 1; m_len[x] = int'(cmd_len); m_fill[x] = 0; m_upd[x] = 0; m_td[x] = 0; m_ovf[x] = 0;
        end else if (cmd_op == 2'd1) begin
          if (m_fill[x] == 0) begin m_len[x] = int'(cmd_len); m_upd[x] = 0; end
          else begin m_nlen[x] = int'(cmd_len); m_upd[x] = 1; end
        end else if (cmd_op == 2'd2) begin
          if (m_fill[x] == 0) begin m_act[x] = 0; m_td[x] = 0; end
          else m_td[x] = 1;
        end
      end
      if (tdm_valid) begin
        idx = int'(tdm_stream) * 8 + int'(tdm_slot);
        x = m_lc[idx];
        if (m_lv[idx] != 0 && m_act[x] != 0 && !(cmd_we && int'(cmd_ctx) == x)) begin
          m_cur[x][m_fill[x]] = int'(tdm_data);
          m_fill[x]++;
          if (m_fill[x] == m_len[x]) begin
            if (m_pend[x] != 0) m_ovf[x] = 1;
            else begin
              m_pend[x] = 1; m_plen[x] = m_len[x];
              for (int i = 0; i < 8; i++) m_pay[x][i] = m_cur[x][i];
            end
            m_fill[x] = 0;
            if (m_upd[x] != 0) begin m_len[x] = m_nlen[x]; m_upd[x] = 0; end
            if (m_td[x] != 0) begin m_act[x] = 0; m_td[x] = 0; end
          end
        end
      end
      if (lut_we) begin m_lv[lut_idx] = int'(lut_valid); m_lc[lut_idx] = int'(lut_ctx); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      int s;
      s = exp_sel();
      chk("R8 mem_req", int'(mem_req), (s >= 0) ? 1 : 0);
      chk("R9 ctx_ovf", int'(ctx_ovf), m_ovf[0] + 2*m_ovf[1] + 4*m_ovf[2] + 8*m_ovf[3]);
      if (s >= 0 && mem_req) begin
        chk("R8 mem_ctx", int'(mem_ctx), s);
        chk("R3 mem_len", int'(mem_len), m_plen[s]);
        for (int i = 0; i < m_plen[s]; i++)
          chk("R3 mem_data byte", int'(mem_data[i*8 +: 8]), m_pay[s][i]);
      end
    end
  end

  task automatic send(input int s, input int t, input int d);
    tdm_valid = 1; tdm_stream = 1'(s); tdm_slot = 3'(t); tdm_data = 8'(d);
    @(negedge clk); tdm_valid = 0;
  endtask

  task automatic cmd(input int op, input int c, input int l);
    cmd_we = 1; cmd_op = 2'(op); cmd_ctx = 2'(c); cmd_len = 4'(l);
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic lut(input int i, input int v, input int c);
    lut_we = 1; lut_idx = 4'(i); lut_valid = 1'(v); lut_ctx = 2'(c);
    @(negedge clk); lut_we = 0;
  endtask

  task automatic grant_one();
    mem_gnt = 1; @(negedge clk); mem_gnt = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mem_req in reset", int'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctx_ovf after reset", int'(ctx_ovf), 0);
    cmd(0, 1, 3);
    send(0, 1, 8'h55);                        // R1: entry not yet valid
    chk("R1 no request, lookup invalid", int'(mem_req), 0);

    lut(1, 1, 1); lut(10, 1, 0); lut(3, 1, 2); lut(15, 1, 3);
    cmd(0, 0, 4); cmd(0, 1, 3); cmd(0, 2, 8); cmd(0, 3, 1);

    send(0, 1, 11); send(0, 1, 12);
    chk("R7 no request before last byte", int'(mem_req), 0);
    send(0, 1, 13);
    chk("R7 request after last byte", int'(mem_req), 1);
    chk("R3 ctx", int'(mem_ctx), 1);
    chk("R3 len", int'(mem_len), 3);
    chk("R3 byte2", int'(mem_data[23:16]), 13);

    send(0, 0, 8'hEE);                        // R2 invalid entry
    send(1, 2, 21); send(1, 2, 22); send(1, 2, 23); send(1, 2, 24);
    chk("R8 lowest context first", int'(mem_ctx), 0);
    chk("R8 len of ctx0", int'(mem_len), 4);

    send(0, 1, 31); send(0, 1, 32); send(0, 1, 33);
    chk("R9 overflow set", int'(ctx_ovf), 2);
    send(0, 1, 41);
    grant_one();
    chk("R8 next pending offered", int'(mem_ctx), 1);
    chk("R9 pending payload kept", int'(mem_data[7:0]), 11);
    grant_one();
    chk("R8 all consumed", int'(mem_req), 0);

    cmd(1, 1, 2);
    send(0, 1, 42); send(0, 1, 43);
    chk("R5 current payload keeps length", int'(mem_len), 3);
    chk("R5 first byte", int'(mem_data[7:0]), 41);
    grant_one();
    send(0, 1, 51); send(0, 1, 52);
    chk("R5 new length applied", int'(mem_len), 2);
    chk("R5 byte1", int'(mem_data[15:8]), 52);
    grant_one();

    send(1, 2, 61);
    cmd(2, 0, 0);
    send(1, 2, 62); send(1, 2, 63); send(1, 2, 64);
    chk("R6 payload completes before teardown", int'(mem_len), 4);
    chk("R6 ctx", int'(mem_ctx), 0);
    grant_one();
    send(1, 2, 65);
    chk("R6 byte after teardown dropped", int'(mem_req), 0);
    cmd(0, 0, 2);
    send(1, 2, 71); send(1, 2, 72);
    chk("R4 reopened context", int'(mem_data[7:0]), 71);
    chk("R4 reopened length", int'(mem_len), 2);
    grant_one();

    send(1, 7, 91);
    chk("R3 single-byte payload ctx", int'(mem_ctx), 3);
    chk("R3 single-byte payload len", int'(mem_len), 1);
    grant_one();
    cmd(2, 3, 0);
    send(1, 7, 92);
    chk("R6 immediate teardown at boundary", int'(mem_req), 0);
    cmd(3, 2, 5);                             // R6 op 3 no effect

    cmd_we = 1; cmd_op = 2'd0; cmd_ctx = 2'd2; cmd_len = 4'd2;
    tdm_valid = 1; tdm_stream = 1'b0; tdm_slot = 3'd3; tdm_data = 8'd81;
    @(negedge clk); cmd_we = 0; tdm_valid = 0;
    send(0, 3, 82);
    chk("R10 simultaneous byte dropped", int'(mem_req), 0);
    send(0, 3, 83);
    chk("R10 payload starts after command", int'(mem_data[7:0]), 82);
    grant_one();

    lut(1, 1, 2);
    send(0, 1, 101); send(0, 1, 102);
    chk("R2 remapped entry routes to ctx2", int'(mem_ctx), 2);
    chk("R2 remapped byte0", int'(mem_data[7:0]), 101);
    grant_one();
    lut(1, 0, 2);
    send(0, 1, 103); send(0, 1, 104);
    chk("R2 invalidated entry discards", int'(mem_req), 0);

    for (int n = 0; n < 4000; n++) begin
      mem_gnt   = 1'($urandom_range(0, 1));
      tdm_valid = ($urandom_range(0, 3) != 0);
      tdm_stream = 1'($urandom_range(0, 1));
      tdm_slot  = 3'($urandom_range(0, 7));
      tdm_data  = 8'($urandom_range(0, 255));
      lut_we    = ($urandom_range(0, 29) == 0);
      lut_idx   = 4'($urandom_range(0, 15));
      lut_valid = ($urandom_range(0, 3) != 0);
      lut_ctx   = 2'($urandom_range(0, 3));
      cmd_we    = ($urandom_range(0, 19) == 0);
      cmd_op    = 2'($urandom_range(0, 3));
      cmd_ctx   = 2'($urandom_range(0, 3));
      cmd_len   = 4'($urandom_range(1, 8));
      @(negedge clk);
    end
    {mem_gnt, tdm_valid, lut_we, cmd_we} = '0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule